// File: doc/BRIEF.md
# ADC Serial Result Output Register

This block models the device side of a converter's serial read port. When the conversion engine reports that a conversion is done, the block takes the signed 24-bit result, five sub-LSB bits and the out-of-range flags. It packs them into a 32-bit word, and a host then shifts the word out while holding chip select low. The host supplies the serial clock. Each falling edge of that clock moves the next word bit onto the data pin, so the host can latch it on the following rising edge.

The first bit of every word is a live "not ready" level. It reads HIGH while no fresh result is waiting and drops LOW as soon as one is captured, so a host can pull chip select low and poll the pin before sending any clock. The serial clock and chip select are asynchronous to the system clock. Each passes through a two-flop synchroniser, and edges are detected in the system clock domain. The system clock is assumed to run at least four times faster than the serial clock.

Top module: `adc_so_top`

## Requirements
- R1: While chip select is HIGH, the output enable is 0 (pin high-impedance), and serial clock edges do not move the word position.
- R2: Word layout, sent from bit 31 down to bit 0: bit 31 is the ready flag (0 = fresh result). Bit 30 is always 0. Bit 29 is the sign. Bits 28..5 hold the 24-bit result with its MSB at bit 28. Bits 4..0 hold the sub-LSBs.
- R3: With chip select LOW and no clock yet, the pin shows the ready flag. The flag is HIGH after reset and goes LOW once a conversion-done pulse is accepted.
- R4: The first falling clock edge puts bit 30 on the pin. The 31st falling edge puts bit 0 on the pin.
- R5: The 32nd falling edge drives the pin HIGH, and the flag stays HIGH until the next accepted conversion. A repeated read returns the same bits 30..0.
- R6: Overrange produces sign = 1 and bit 28 = 1, with bits 27..0 all 0.
- R7: Underrange produces sign = 0 and bit 28 = 0, with bits 27..0 all 1. If both flags are set, overrange wins.
- R8: If chip select rises after at least one falling edge of a word, the word is dropped. The next read starts again at bit 31, with the flag HIGH.
- R9: A conversion-done pulse is ignored in two cases: while a word is part-way out, or in the same system cycle as the falling edge that starts a word. The word in flight continues unchanged.
- R10: After reset, the output enable is 0 and the flag is HIGH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_done_i | input | 1 | One-cycle pulse: a new result is present on the conv inputs |
| conv_sign_i | input | 1 | Sign of the result |
| conv_result_i | input | 24 | Result magnitude bits, MSB first |
| conv_sub_i | input | 5 | Sub-LSB bits |
| conv_over_i | input | 1 | Input above positive full scale |
| conv_under_i | input | 1 | Input below negative full scale |
| sck_i | input | 1 | Serial clock from the host, idles LOW |
| csn_i | input | 1 | Chip select from the host, active LOW |
| sdo_o | output | 1 | Serial data pin, high-impedance while deselected |
| sdo_oe_o | output | 1 | Drive enable for the data pin |

## Verification
A conversion-done pulse can land in the same system cycle as the synchronised falling edge that starts shifting a word. In that case the shift takes priority and the new result is dropped. The bench provokes this by placing the pulse exactly two system cycles after it lowers the serial clock, which lines up with the synchroniser delay. A correct design passes the old word's bits 30..0 and then reads HIGH on later reads. A control run moves the pulse one cycle earlier; that pulse must be accepted and must appear in the word being shifted.

// File: rtl/adc_so_pkg.sv
package adc_so_pkg;

    localparam int RES_W   = 24;
    localparam int SUB_W   = 5;
    localparam int LOW_W   = RES_W + SUB_W;      // bits 28..0
    localparam int PAY_W   = LOW_W + 1;          // sign + low part
    localparam int FRAME_W = PAY_W + 2;          // flag + zero + payload
    localparam int CNT_W   = $clog2(FRAME_W);

    typedef struct packed {
        logic             sign;
        logic [RES_W-1:0] res;
        logic [SUB_W-1:0] sub;
    } conv_word_t;

    typedef enum logic [1:0] {
        RNG_NORMAL = 2'd0,
        RNG_OVER   = 2'd1,
        RNG_UNDER  = 2'd2
    } range_e;

    function automatic range_e classify(logic over, logic under);
        if (over)
            return RNG_OVER;
        else if (under)
            return RNG_UNDER;
        else
            return RNG_NORMAL;
    endfunction

    // bit FRAME_W-1 is a placeholder; the live flag is muxed in elsewhere
    function automatic logic [FRAME_W-1:0] build_frame(conv_word_t w, range_e r);
        logic [PAY_W-1:0] p;
        case (r)
            RNG_OVER:  p = {1'b1, 1'b1, {(LOW_W-1){1'b0}}};
            RNG_UNDER: p = {1'b0, 1'b0, {(LOW_W-1){1'b1}}};
            default:   p = {w.sign, w.res, w.sub};
        endcase
        return {2'b00, p};
    endfunction

endpackage

// File: rtl/adc_so_sync.sv
module adc_so_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic async_i,
    output logic level_o,
    output logic prev_o
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    chain[g] <= RST_VAL;
                else if (g == 0)
                    chain[g] <= async_i;
                else
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            prev_o <= RST_VAL;
        else
            prev_o <= chain[STAGES-1];
    end

    assign level_o = chain[STAGES-1];
endmodule

// File: rtl/adc_so_frame.sv
module adc_so_frame
    import adc_so_pkg::*;
(
    input  logic               sign_i,
    input  logic [RES_W-1:0]   result_i,
    input  logic [SUB_W-1:0]   sub_i,
    input  logic               over_i,
    input  logic               under_i,
    output logic [FRAME_W-1:0] frame_o
);
    conv_word_t w;
    range_e     rng;

    always_comb begin
        w.sign  = sign_i;
        w.res   = result_i;
        w.sub   = sub_i;
        rng     = classify(over_i, under_i);
        frame_o = build_frame(w, rng);
    end
endmodule

// File: rtl/adc_so_shift.sv
module adc_so_shift
    import adc_so_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               cs_active,
    input  logic               cs_rise,
    input  logic               sck_fall,
    input  logic               conv_done,
    input  logic [FRAME_W-1:0] frame_i,
    output logic               sdo_d,
    output logic [CNT_W-1:0]   cnt_o,
    output logic               eoc_n_o
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1);

    logic [FRAME_W-1:0] held_q, sr_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               eoc_n_q;
    logic               busy, shift_en, accept;

    always_comb begin
        busy     = (cnt_q != '0);
        shift_en = cs_active && sck_fall;
        accept   = conv_done && !busy && !shift_en;   // shift wins a tie
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            eoc_n_q <= 1'b1;
            sr_q    <= '0;
            held_q  <= '0;
        end else if (cs_rise && busy) begin
            cnt_q   <= '0;
            eoc_n_q <= 1'b1;
            sr_q    <= held_q;
        end else if (shift_en) begin
            if (cnt_q == LAST) begin
                cnt_q   <= '0;
                eoc_n_q <= 1'b1;
                sr_q    <= held_q;
            end else begin
                cnt_q <= cnt_q + 1'b1;
                sr_q  <= {sr_q[FRAME_W-2:0], 1'b0};
            end
        end else if (accept) begin
            held_q  <= frame_i;
            sr_q    <= frame_i;
            eoc_n_q <= 1'b0;
        end
    end

    assign sdo_d   = busy ? sr_q[FRAME_W-1] : eoc_n_q;
    assign cnt_o   = cnt_q;
    assign eoc_n_o = eoc_n_q;
endmodule

// File: rtl/adc_so_top.sv
module adc_so_top
    import adc_so_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             conv_done_i,
    input  logic             conv_sign_i,
    input  logic [RES_W-1:0] conv_result_i,
    input  logic [SUB_W-1:0] conv_sub_i,
    input  logic             conv_over_i,
    input  logic             conv_under_i,
    input  logic             sck_i,
    input  logic             csn_i,
    output logic             sdo_o,
    output logic             sdo_oe_o
);
    logic sck_lvl, sck_prev, csn_lvl, csn_prev;
    logic cs_active, cs_rise, sck_fall, sdo_d, eoc_n;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] frame;

    adc_so_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
        .clk(clk), .rst(rst), .async_i(sck_i), .level_o(sck_lvl), .prev_o(sck_prev)
    );

    adc_so_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_csn_sync (
        .clk(clk), .rst(rst), .async_i(csn_i), .level_o(csn_lvl), .prev_o(csn_prev)
    );

    assign cs_active = !csn_lvl;
    assign cs_rise   = csn_lvl && !csn_prev;
    assign sck_fall  = sck_prev && !sck_lvl;

    adc_so_frame u_frame (
        .sign_i(conv_sign_i), .result_i(conv_result_i), .sub_i(conv_sub_i),
        .over_i(conv_over_i), .under_i(conv_under_i), .frame_o(frame)
    );

    adc_so_shift u_shift (
        .clk(clk), .rst(rst), .cs_active(cs_active), .cs_rise(cs_rise),
        .sck_fall(sck_fall), .conv_done(conv_done_i), .frame_i(frame),
        .sdo_d(sdo_d), .cnt_o(cnt), .eoc_n_o(eoc_n)
    );

    assign sdo_oe_o = cs_active;
    assign sdo_o    = sdo_oe_o ? sdo_d : 1'bz;
endmodule

// File: rtl/adc_so_checker.sv
module adc_so_checker #(
    parameter int CNT_W = 5,
    parameter int LAST  = 31
) (
    input logic             clk,
    input logic             rst,
    input logic             cs_active,
    input logic             cs_rise,
    input logic             sck_fall,
    input logic             conv_done_i,
    input logic [CNT_W-1:0] cnt,
    input logic             eoc_n
);
    p_no_move_deselected_r1: assert property (@(posedge clk) disable iff (rst)
        (!cs_active && sck_fall && !cs_rise) |=> $stable(cnt));

    p_accept_lowers_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (conv_done_i && cnt == '0 && !(cs_active && sck_fall)) |=> !eoc_n);

    p_advance_on_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (cs_active && sck_fall && cnt != CNT_W'(LAST)) |=> cnt == $past(cnt) + 1'b1);

    p_rearm_high_r5: assert property (@(posedge clk) disable iff (rst)
        (cs_active && sck_fall && cnt == CNT_W'(LAST)) |=> (cnt == '0 && eoc_n));

    p_abandon_r8: assert property (@(posedge clk) disable iff (rst)
        (cs_rise && cnt != '0) |=> (cnt == '0 && eoc_n));

    p_busy_ignores_done_r9: assert property (@(posedge clk) disable iff (rst)
        (conv_done_i && cnt != '0 && cnt != CNT_W'(LAST) && !cs_rise) |=> eoc_n == $past(eoc_n));
endmodule

bind adc_so_top adc_so_checker #(.CNT_W(adc_so_pkg::CNT_W), .LAST(adc_so_pkg::FRAME_W - 1)) u_chk (
    .clk(clk), .rst(rst), .cs_active(cs_active), .cs_rise(cs_rise),
    .sck_fall(sck_fall), .conv_done_i(conv_done_i), .cnt(cnt), .eoc_n(eoc_n)
);

// File: tb/adc_so_top_tb.sv
module adc_so_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        conv_done = 1'b0, sign = 1'b0, over = 1'b0, under = 1'b0;
    logic [23:0] result = '0;
    logic [4:0]  sub = '0;
    logic        sck = 1'b0, csn = 1'b1;
    logic        sdo, sdo_oe;
    int          n_cmp = 0, n_bad = 0;

    always #5 clk = ~clk;

    adc_so_top dut_i (
        .clk(clk), .rst(rst), .conv_done_i(conv_done), .conv_sign_i(sign),
        .conv_result_i(result), .conv_sub_i(sub), .conv_over_i(over),
        .conv_under_i(under), .sck_i(sck), .csn_i(csn),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    // stimulus word: {over, under, sign, result[23:0], sub[4:0]}
    localparam logic [31:0] STIM [8] = '{
        32'h34B87E15, 32'h02468ACA, 32'h801FFFE3, 32'h68000000,
        32'hC0000000, 32'h3FFFFFFF, 32'h00000000, 32'h10000030 };
    localparam logic [31:0] EXP [8] = '{
        32'h34B87E15, 32'h02468ACA, 32'h30000000, 32'h0FFFFFFF,
        32'h30000000, 32'h3FFFFFFF, 32'h00000000, 32'h10000030 };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_conv(input logic [31:0] s);
        @(negedge clk);
        {over, under, sign, result, sub} = s;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        wait_n(2);
    endtask

    task automatic one_clock;
        sck = 1'b1; wait_n(8);
        sck = 1'b0; wait_n(8);
    endtask

    task automatic cs_low;
        @(negedge clk); csn = 1'b0; wait_n(6);
    endtask

    task automatic cs_high;
        @(negedge clk); csn = 1'b1; wait_n(6);
    endtask

    // CS low, 32 clocks, CS high; returns the word and the level after clock 32
    task automatic read_frame(output logic [31:0] w, output logic after);
        cs_low();
        w[31] = sdo;
        for (int k = 1; k < 32; k++) begin
            one_clock();
            w[31-k] = sdo;
        end
        one_clock();
        after = sdo;
        cs_high();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] w;
        logic        a;
        wait_n(4);
        rst = 1'b0;
        wait_n(4);

        // R10: reset state
        check("R10 oe", {31'd0, sdo_oe}, 32'd0);
        cs_low();
        check("R10 R3 flag high", {31'd0, sdo}, 32'd1);
        cs_high();

        // R2 R6 R7 R4 R5: table walk
        for (int i = 0; i < 8; i++) begin
            pulse_conv(STIM[i]);
            read_frame(w, a);
            check("R2 R4 R6 R7 word", w, EXP[i]);
            check("R5 high after 32nd", {31'd0, a}, 32'd1);
        end

        // R5: repeat read, flag high, same bits 30..0
        read_frame(w, a);
        check("R5 repeat read", w, {1'b1, EXP[7][30:0]});

        // R1: clocks while deselected do nothing, pin not driven
        pulse_conv(STIM[0]);
        check("R1 oe off", {31'd0, sdo_oe}, 32'd0);
        for (int k = 0; k < 5; k++) one_clock();
        check("R1 oe still off", {31'd0, sdo_oe}, 32'd0);
        read_frame(w, a);
        check("R1 R3 word intact", w, EXP[0]);

        // R8: abandon mid-word
        pulse_conv(STIM[1]);
        cs_low();
        check("R3 flag low", {31'd0, sdo}, 32'd0);
        for (int k = 0; k < 10; k++) one_clock();
        cs_high();
        read_frame(w, a);
        check("R8 restart flag high", w, {1'b1, EXP[1][30:0]});

        // R9: done mid-word is ignored
        pulse_conv(STIM[5]);
        cs_low();
        for (int k = 1; k < 32; k++) begin
            one_clock();
            w[31-k] = sdo;
            if (k == 10) begin
                @(negedge clk);
                {over, under, sign, result, sub} = STIM[6];
                conv_done = 1'b1;
                @(negedge clk);
                conv_done = 1'b0;
            end
        end
        one_clock();
        cs_high();
        check("R9 mid-word", {1'b0, w[30:0]}, {1'b0, EXP[5][30:0]});
        read_frame(w, a);
        check("R9 flag stays high", {31'd0, w[31]}, 32'd1);

        // R9: done in same cycle as first synced fall -> dropped
        pulse_conv(STIM[0]);
        cs_low();
        sck = 1'b1; wait_n(8);
        sck = 1'b0;
        wait_n(2);
        {over, under, sign, result, sub} = STIM[1];
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        wait_n(5);
        w[30] = sdo;
        for (int k = 2; k < 32; k++) begin
            one_clock();
            w[31-k] = sdo;
        end
        one_clock();
        cs_high();
        check("R9 tie shift wins", {1'b0, w[30:0]}, {1'b0, EXP[0][30:0]});
        read_frame(w, a);
        check("R9 tie dropped flag", {31'd0, w[31]}, 32'd1);

        // R3 control: done one cycle earlier is accepted and shifted
        cs_low();
        sck = 1'b1; wait_n(8);
        sck = 1'b0;
        wait_n(1);
        {over, under, sign, result, sub} = STIM[7];
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        wait_n(6);
        w[30] = sdo;
        for (int k = 2; k < 32; k++) begin
            one_clock();
            w[31-k] = sdo;
        end
        one_clock();
        check("R3 early done shifted", {1'b0, w[30:0]}, {1'b0, EXP[7][30:0]});
        check("R5 after early", {31'd0, sdo}, 32'd1);
        cs_high();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule